// File: doc/BRIEF.md
# Board Controller Register Bank

This block is the register file inside a board management controller. It has sixteen 16-bit word slots behind a plain synchronous access port: address, write strobe, write data and registered read data. The slots fall into groups, and each group has its own access rule. Three slots hold fixed identifier constants. Three slots hold writable control words, and these are driven out continuously to the routing logic for the LEDs, the external I/O pins and the reset/interrupt functions. One slot mirrors a live status input. Three slots return the 48-bit primary hardware address in high, middle and low parts. Two writable scratch slots are kept for a future extended-access scheme and drive nothing.

Every other address is reserved. Slots 0 and 1 are also read-only and unused. All of these read as zero, and writes to them are discarded. A serial bus front end, which is not part of this block, translates its transactions into port cycles.

Top module: `ctlr_regbank`

## Requirements
- R1: After reset (rst_n low on a clock edge), the three control words and the two scratch words are 0x0000, and rd_data is 0x0000.
- R2: Read data is registered. The value for the address presented on edge N appears on rd_data after edge N and stays until the next edge.
- R3: Addresses 2, 3 and 4 read the constant parameters ID_WORD0, ID_WORD1 and ID_WORD2. A write to them is ignored.
- R4: Addresses 5, 6 and 7 are read-write control words. A write with wr_en high takes effect on that edge and appears on ctrl_led, ctrl_xio and ctrl_rst respectively.
- R5: Address 8 returns the status_in input as sampled on the read edge. Writes to it are ignored.
- R6: Addresses 9, 0xA and 0xB return hw_addr[47:32], hw_addr[31:16] and hw_addr[15:0]. Writes to them are ignored.
- R7: Addresses 0xD and 0xE are read-write scratch words. They read back what was written, and no output port changes when they are written.
- R8: Addresses 0, 1, 0xC and 0xF read 0x0000 and drop writes. Such a write leaves every control output unchanged.
- R9: A write and a read at the same address on the same edge returns the old contents, because the read sees the value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| status_in | input | 16 | Live status word |
| hw_addr | input | 48 | Primary hardware address |
| ctrl_led | output | 16 | LED routing control word |
| ctrl_xio | output | 16 | External I/O routing control word |
| ctrl_rst | output | 16 | Reset/interrupt control word |

## Verification
A write takes effect on the edge where it is presented, so the control outputs are checked half a period after that edge. Read data is due one edge after the address is presented. The bench drives each input half a period before an edge and samples rd_data at the following falling edge. Ignored writes are checked two ways: by reading the target address back and by comparing the three control outputs just after the write edge.

// File: rtl/ctlr_regbank_pkg.sv
// Package: address map constants shared by the register bank modules.
package ctlr_regbank_pkg;
    localparam int unsigned DW = 16;
    localparam int unsigned AW = 4;

    // Word slot numbers. These are fixed because external software decodes them.
    localparam logic [AW-1:0] A_ID0   = 4'h2;
    localparam logic [AW-1:0] A_ID1   = 4'h3;
    localparam logic [AW-1:0] A_ID2   = 4'h4;
    localparam logic [AW-1:0] A_LED   = 4'h5;
    localparam logic [AW-1:0] A_XIO   = 4'h6;
    localparam logic [AW-1:0] A_RST   = 4'h7;
    localparam logic [AW-1:0] A_STAT  = 4'h8;
    localparam logic [AW-1:0] A_HWHI  = 4'h9;
    localparam logic [AW-1:0] A_HWMID = 4'hA;
    localparam logic [AW-1:0] A_HWLO  = 4'hB;
    localparam logic [AW-1:0] A_SCR0  = 4'hD;
    localparam logic [AW-1:0] A_SCR1  = 4'hE;

    // Access class assigned to each slot by the decoder.
    typedef enum logic [2:0] {
        K_NONE,
        K_ID,
        K_CTRL,
        K_STAT,
        K_HW,
        K_SCR
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e  kind;
        logic [1:0]  idx;   // index of the slot within its group
    } slot_dec_t;
endpackage

// File: rtl/ctlr_regbank_dec.sv
// Module: address decoder.
// Purpose: classifies a word address into an access class and a group index.
// Assumes: the map is fixed. Every address outside the listed slots is K_NONE.
module ctlr_regbank_dec
    import ctlr_regbank_pkg::*;
(
    input  logic [AW-1:0] addr,
    output slot_dec_t     dec
);
    // Combinational map lookup.
    always_comb begin
        dec = '{kind: K_NONE, idx: 2'd0};
        unique case (addr)
            A_ID0:   dec = '{kind: K_ID,   idx: 2'd0};
            A_ID1:   dec = '{kind: K_ID,   idx: 2'd1};
            A_ID2:   dec = '{kind: K_ID,   idx: 2'd2};
            A_LED:   dec = '{kind: K_CTRL, idx: 2'd0};
            A_XIO:   dec = '{kind: K_CTRL, idx: 2'd1};
            A_RST:   dec = '{kind: K_CTRL, idx: 2'd2};
            A_STAT:  dec = '{kind: K_STAT, idx: 2'd0};
            A_HWHI:  dec = '{kind: K_HW,   idx: 2'd2};
            A_HWMID: dec = '{kind: K_HW,   idx: 2'd1};
            A_HWLO:  dec = '{kind: K_HW,   idx: 2'd0};
            A_SCR0:  dec = '{kind: K_SCR,  idx: 2'd0};
            A_SCR1:  dec = '{kind: K_SCR,  idx: 2'd1};
            default: dec = '{kind: K_NONE, idx: 2'd0};
        endcase
    end
endmodule

// File: rtl/ctlr_regbank_store.sv
// Module: writable word storage.
// Purpose: holds N_WORDS read-write words of DW bits. Each word loads when its
//          write strobe is set and clears to zero on synchronous reset.
// Assumes: at most one strobe is set per cycle. The caller decodes them.
module ctlr_regbank_store #(
    parameter int unsigned N_WORDS = 3,
    parameter int unsigned DW      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_WORDS-1:0]          we,
    input  logic [DW-1:0]               wdata,
    output logic [N_WORDS-1:0][DW-1:0]  q
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        // Per-word register with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[g] <= '0;
            else if (we[g]) q[g] <= wdata;
        end
    end
endmodule

// File: rtl/ctlr_regbank.sv
// Module: board controller register bank (top).
// Purpose: a 16-slot register file with per-group access rules. It drives the
//          control words out to the routing logic and registers the read data.
// Assumes: synchronous active-low reset, a single clock, and a port access
//          every cycle. Writes to read-only or reserved slots are dropped.
module ctlr_regbank
    import ctlr_regbank_pkg::*;
#(
    parameter logic [15:0] ID_WORD0 = 16'h5C01,
    parameter logic [15:0] ID_WORD1 = 16'h0002,
    parameter logic [15:0] ID_WORD2 = 16'hA720
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic [15:0] status_in,
    input  logic [47:0] hw_addr,
    output logic [15:0] ctrl_led,
    output logic [15:0] ctrl_xio,
    output logic [15:0] ctrl_rst
);
    localparam int unsigned N_CTRL = 3;
    localparam int unsigned N_SCR  = 2;
    localparam int unsigned N_HW   = 48 / DW;

    slot_dec_t                    dec;
    logic [N_CTRL-1:0]            ctrl_we;
    logic [N_SCR-1:0]             scr_we;
    logic [N_CTRL-1:0][DW-1:0]    ctrl_q;
    logic [N_SCR-1:0][DW-1:0]     scr_q;
    logic [N_HW-1:0][DW-1:0]      hw_w;
    logic [2:0][DW-1:0]           id_w;
    logic [DW-1:0]                rd_next;

    ctlr_regbank_dec u_dec (.addr(addr), .dec(dec));

    assign id_w = {ID_WORD2, ID_WORD1, ID_WORD0};

    for (genvar h = 0; h < N_HW; h++) begin : g_hw
        assign hw_w[h] = hw_addr[h*DW +: DW];
    end

    // Write strobes go only to the writable groups.
    always_comb begin
        ctrl_we = '0;
        scr_we  = '0;
        if (wr_en && dec.kind == K_CTRL) ctrl_we[dec.idx] = 1'b1;
        if (wr_en && dec.kind == K_SCR)  scr_we[dec.idx[0]] = 1'b1;
    end

    ctlr_regbank_store #(.N_WORDS(N_CTRL), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(wr_data), .q(ctrl_q));

    ctlr_regbank_store #(.N_WORDS(N_SCR), .DW(DW)) u_scr (
        .clk(clk), .rst_n(rst_n), .we(scr_we), .wdata(wr_data), .q(scr_q));

    assign ctrl_led = ctrl_q[0];
    assign ctrl_xio = ctrl_q[1];
    assign ctrl_rst = ctrl_q[2];

    // Read mux: select the word for the current slot class.
    always_comb begin
        unique case (dec.kind)
            K_ID:    rd_next = id_w[dec.idx];
            K_CTRL:  rd_next = ctrl_q[dec.idx];
            K_STAT:  rd_next = status_in;
            K_HW:    rd_next = hw_w[dec.idx];
            K_SCR:   rd_next = scr_q[dec.idx[0]];
            default: rd_next = '0;
        endcase
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    // ---------------- assertions ----------------
    // R1: after reset, the control words are zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_led == '0 && ctrl_xio == '0 && ctrl_rst == '0 && rd_data == '0));

    // R4: a control write appears on the next cycle.
    assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_XIO) |=> ctrl_xio == $past(wr_data));

    // R5: status reads return the status sampled one cycle earlier.
    assert_status_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_STAT) |=> rd_data == $past(status_in));

    // R8: reserved addresses read zero.
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'h0 || addr == 4'h1 || addr == 4'hC || addr == 4'hF) |=> rd_data == '0);

    // R7 and R8: writes outside the control slots leave the control outputs alone.
    assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_LED || addr == A_XIO || addr == A_RST))
        |=> ($stable(ctrl_led) && $stable(ctrl_xio) && $stable(ctrl_rst)));

    // R3: identifier reads return the constant.
    assert_id_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_ID1) |=> rd_data == ID_WORD1);
endmodule

// File: tb/ctlr_regbank_bench.sv
// Directed bench for ctlr_regbank. Inputs change on the falling edge and
// outputs are sampled on the falling edge after the edge of interest.
module ctlr_regbank_bench;
    localparam logic [15:0] I0 = 16'h5C01, I1 = 16'h0002, I2 = 16'hA720;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, status_in = 16'h0000;
    logic [47:0] hw_addr = 48'h0012_3456_789A;
    logic [15:0] ctrl_led, ctrl_xio, ctrl_rst;

    int n_chk = 0, n_bad = 0;

    ctlr_regbank #(.ID_WORD0(I0), .ID_WORD1(I1), .ID_WORD2(I2)) u_ctlr_regbank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .status_in(status_in), .hw_addr(hw_addr),
        .ctrl_led(ctrl_led), .ctrl_xio(ctrl_xio), .ctrl_rst(ctrl_rst));

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive the inputs, pass one rising edge, return at the falling edge.
    task automatic cyc(input logic [3:0] a, input logic w, input logic [15:0] d);
        addr = a; wr_en = w; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
        cyc(a, 1'b0, '0);
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset;
        chk("R1 led", ctrl_led, 16'h0); chk("R1 xio", ctrl_xio, 16'h0);
        chk("R1 rst", ctrl_rst, 16'h0); chk("R1 rd", rd_data, 16'h0);
        rd("R1 scratch", 4'hD, 16'h0);
    endtask

    task automatic t_ids;
        rd("R3 id0", 4'h2, I0); rd("R3 id1", 4'h3, I1); rd("R3 id2", 4'h4, I2);
        cyc(4'h3, 1'b1, 16'hFFFF);
        rd("R3 id1 after write", 4'h3, I1);
    endtask

    task automatic t_ctrl;
        cyc(4'h5, 1'b1, 16'h1234); chk("R4 led out", ctrl_led, 16'h1234);
        cyc(4'h6, 1'b1, 16'h0765); chk("R4 xio out", ctrl_xio, 16'h0765);
        cyc(4'h7, 1'b1, 16'hBEEF); chk("R4 rst out", ctrl_rst, 16'hBEEF);
        rd("R4 read led", 4'h5, 16'h1234);
        rd("R2 read rst", 4'h7, 16'hBEEF);
    endtask

    task automatic t_status;
        status_in = 16'hC3A5;
        rd("R5 status", 4'h8, 16'hC3A5);
        cyc(4'h8, 1'b1, 16'h0000);
        status_in = 16'h0F0F;
        rd("R5 status live", 4'h8, 16'h0F0F);
    endtask

    task automatic t_hw;
        rd("R6 hi", 4'h9, 16'h0012); rd("R6 mid", 4'hA, 16'h3456); rd("R6 lo", 4'hB, 16'h789A);
        cyc(4'hB, 1'b1, 16'h1111);
        rd("R6 lo after write", 4'hB, 16'h789A);
    endtask

    task automatic t_scratch;
        cyc(4'hD, 1'b1, 16'hAAAA);
        chk("R7 led held", ctrl_led, 16'h1234); chk("R7 xio held", ctrl_xio, 16'h0765);
        cyc(4'hE, 1'b1, 16'h5555);
        chk("R7 rst held", ctrl_rst, 16'hBEEF);
        rd("R7 scr0", 4'hD, 16'hAAAA); rd("R7 scr1", 4'hE, 16'h5555);
    endtask

    task automatic t_reserved;
        foreach (addr_list[i]) begin
            cyc(addr_list[i], 1'b1, 16'h9999);
            chk("R8 led", ctrl_led, 16'h1234); chk("R8 xio", ctrl_xio, 16'h0765);
            chk("R8 rst", ctrl_rst, 16'hBEEF);
            rd("R8 reads zero", addr_list[i], 16'h0000);
        end
    endtask
    logic [3:0] addr_list [4] = '{4'h0, 4'h1, 4'hC, 4'hF};

    task automatic t_rmw;
        cyc(4'h6, 1'b1, 16'h4321);
        chk("R9 old value", rd_data, 16'h0765);
        rd("R9 new value", 4'h6, 16'h4321);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        t_reset; t_ids; t_ctrl; t_status; t_hw; t_scratch; t_reserved; t_rmw;
        rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
        chk("R1 led after reset", ctrl_led, 16'h0);
        chk("R1 xio after reset", ctrl_xio, 16'h0);
        rd("R1 scratch after reset", 4'hD, 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule